// File: doc/BRIEF.md
# Input Port with Change-of-State Detection

This block is a narrow general-purpose input port. Seven input pins pass through a two-stage synchroniser and can be read at any time, with the top data bit forced to one. The four lowest inputs are also watched for level changes. Each watched input is sampled only when a slow sampling tick is high. The tick comes from outside the block and is nominally about 38.4 kHz, taken from the baud clock.

A new level counts only once two successive tick samples both show it. A short excursion is therefore ignored, and a real change must last one to two tick periods before it is seen. A confirmed change in either direction sets a sticky flag. The flags and the current filtered levels are read together from a change register, and that read clears the flags. A per-input mask selects which flags drive the interrupt output.

Top module: `ip_cos_port`

## Requirements
- R1: `port_data_o[6:0]` equals `pins_i` delayed by two clock edges of synchronisation, and `port_data_o[7]` always reads 1.
- R2: Level changes on inputs 4 to 6 never set a change flag.
- R3: On a watched input, a confirmed rising change and a confirmed falling change both set that input's flag.
- R4: A new level is accepted only after two consecutive tick samples at that level. A level that lasts for one tick sample and then reverts sets no flag and leaves the filtered level unchanged. Without ticks, nothing changes.
- R5: The flag and the filtered level both update at the clock edge where the second confirming tick is sampled.
- R6: Flags stay set until the change register is read. A read (`chg_rd_i` high for one cycle) returns the current value and clears the flags at the end of that cycle.
- R7: If a change is confirmed in the same cycle as a clearing read, that flag ends up set. The read itself returns the value from before the change.
- R8: After reset, the first tick sample sets the filtered level directly and raises no flag. The filtered levels read 0 until that first sample.
- R9: Layout of `chg_data_o`: bit 4+i holds the flag of input i, and bit i holds the filtered level of input i, for i = 0 to 3.
- R10: `irq_o` is high exactly when some input i has both its flag and `irq_mask_i[i]` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 7 | Asynchronous input pins |
| tick_i | input | 1 | Sampling tick, one clock wide |
| chg_rd_i | input | 1 | Change register read strobe (clears flags) |
| irq_mask_i | input | 4 | Interrupt enable per watched input |
| port_data_o | output | 8 | Direct port value, bit 7 fixed at 1 |
| chg_data_o | output | 8 | Change flags [7:4], filtered levels [3:0] |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: seven inputs, four watched inputs and two synchroniser stages. These values make the fixed high bit, the unwatched upper inputs and the 4+4 change register layout all visible at the ports. With the tick under direct control, the bench can place single-sample glitches, two-sample confirmations and a confirmation that falls in the same cycle as a clearing read.

// File: rtl/ip_cos_pkg.sv
package ip_cos_pkg;
    // Per-input filter state
    typedef struct packed {
        logic lvl;   // confirmed (filtered) level
        logic pend;  // one sample seen at the opposite level
        logic init;  // reference level has been taken
    } flt_state_t;

    localparam flt_state_t FLT_RESET = '{lvl: 1'b0, pend: 1'b0, init: 1'b0};
endpackage

// File: rtl/ip_sync.sv
module ip_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);
    logic [W-1:0] st_d [STAGES];
    logic [W-1:0] st_q [STAGES];

    always_comb begin
        st_d[0] = din_i;
        for (int k = 1; k < STAGES; k++) begin
            st_d[k] = st_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) st_q[k] <= '0;
        end else begin
            for (int k = 0; k < STAGES; k++) st_q[k] <= st_d[k];
        end
    end

    assign dout_o = st_q[STAGES-1];
endmodule

// File: rtl/ip_cos_filter.sv
module ip_cos_filter
    import ip_cos_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic samp_i,
    output logic lvl_o,
    output logic chg_o
);
    flt_state_t st_d, st_q;
    logic       confirm;

    always_comb begin
        st_d    = st_q;
        confirm = 1'b0;
        if (tick_i) begin
            if (!st_q.init) begin
                // first sample becomes the reference, no event
                st_d.lvl  = samp_i;
                st_d.init = 1'b1;
                st_d.pend = 1'b0;
            end else if (samp_i != st_q.lvl) begin
                if (st_q.pend) begin
                    st_d.lvl  = samp_i;
                    st_d.pend = 1'b0;
                    confirm   = 1'b1;
                end else begin
                    st_d.pend = 1'b1;
                end
            end else begin
                st_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLT_RESET;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.lvl;
    assign chg_o = confirm;

    // R4: filtered level never moves between ticks
    p_hold_without_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(st_q.lvl));

    // R4: once initialised, a level change needs a pending sample before it
    p_two_samples_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.init) && !$stable(st_q.lvl)) |-> $past(st_q.pend));
endmodule

// File: rtl/ip_chg_reg.sv
module ip_chg_reg #(
    parameter int MON_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MON_W-1:0] set_i,
    input  logic             rd_i,
    input  logic [MON_W-1:0] mask_i,
    output logic [MON_W-1:0] flags_o,
    output logic             irq_o
);
    logic [MON_W-1:0] flags_d, flags_q;

    always_comb begin
        // set has priority over the clear from a read
        flags_d = (flags_q & ~{MON_W{rd_i}}) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;
    assign irq_o   = |(flags_q & mask_i);

    // R6: no flag drops without a read
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R6: a read with no new event leaves all flags clear
    p_clear_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && set_i == '0) |=> (flags_q == '0));

    // R7: a confirmed event always lands, even during a read
    p_set_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));

    // R10: an all-zero mask keeps the interrupt low
    p_mask_blocks_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |-> !irq_o);
endmodule

// File: rtl/ip_cos_port.sv
module ip_cos_port #(
    parameter int IN_W        = 7,
    parameter int MON_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IN_W-1:0]    pins_i,
    input  logic               tick_i,
    input  logic               chg_rd_i,
    input  logic [MON_W-1:0]   irq_mask_i,
    output logic [IN_W:0]      port_data_o,
    output logic [2*MON_W-1:0] chg_data_o,
    output logic               irq_o
);
    localparam int CHG_W = 2 * MON_W;

    logic [IN_W-1:0]  pins_s;
    logic [MON_W-1:0] lvl;
    logic [MON_W-1:0] evt;
    logic [MON_W-1:0] flags;

    initial begin
        if (MON_W > IN_W) $error("MON_W must not exceed IN_W");
        if (SYNC_STAGES < 1) $error("SYNC_STAGES must be at least 1");
    end

    ip_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (pins_i),
        .dout_o (pins_s)
    );

    for (genvar i = 0; i < MON_W; i++) begin : g_flt
        ip_cos_filter u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick_i),
            .samp_i (pins_s[i]),
            .lvl_o  (lvl[i]),
            .chg_o  (evt[i])
        );
    end

    ip_chg_reg #(.MON_W(MON_W)) u_chg (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (evt),
        .rd_i    (chg_rd_i),
        .mask_i  (irq_mask_i),
        .flags_o (flags),
        .irq_o   (irq_o)
    );

    assign port_data_o = {1'b1, pins_s};
    assign chg_data_o  = {flags, lvl};

    // R2/R5: a flag rises only alongside a move of its filtered level
    p_flag_with_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((chg_data_o[CHG_W-1:MON_W] & ~$past(chg_data_o[CHG_W-1:MON_W])) != '0)
        |-> (lvl != $past(lvl)));
endmodule

// File: tb/sim_ip_cos_port.sv
module sim_ip_cos_port;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] pins = 7'h05;
    logic       tick = 1'b0;
    logic       rd = 1'b0;
    logic [3:0] mask = 4'h0;
    logic [7:0] port_data;
    logic [7:0] chg_data;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ip_cos_port u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .pins_i      (pins),
        .tick_i      (tick),
        .chg_rd_i    (rd),
        .irq_mask_i  (mask),
        .port_data_o (port_data),
        .chg_data_o  (chg_data),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_pins(input logic [6:0] v);
        @(negedge clk) pins = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic tick_once();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic read_chg(output logic [7:0] v);
        @(negedge clk) rd = 1'b1;
        v = chg_data;
        @(negedge clk) rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset port", port_data, 8'h85);
        check("R8 reset chg", chg_data, 8'h00);
        check("R10 reset irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_first_sample();
        tick_once();
        check("R8 first sample", chg_data, 8'h05);
    endtask

    task automatic t_glitch();
        set_pins(7'h07);
        repeat (10) @(negedge clk);
        check("R4 no tick", chg_data, 8'h05);
        tick_once();
        check("R4 one sample", chg_data, 8'h05);
        set_pins(7'h05);
        tick_once();
        check("R4 glitch dropped", chg_data, 8'h05);
    endtask

    task automatic t_rise_read();
        logic [7:0] v;
        set_pins(7'h07);
        tick_once();
        check("R5 pending", chg_data, 8'h05);
        tick_once();
        check("R3 rise confirmed", chg_data, 8'h27);
        read_chg(v);
        check("R6 read value", v, 8'h27);
        check("R6 cleared", chg_data, 8'h07);
    endtask

    task automatic t_fall_sticky();
        logic [7:0] v;
        set_pins(7'h06);
        tick_once(); tick_once();
        check("R3 fall confirmed", chg_data, 8'h16);
        set_pins(7'h0E);
        tick_once(); tick_once();
        check("R6 sticky R9 layout", chg_data, 8'h9E);
        read_chg(v);
        check("R6 read value 2", v, 8'h9E);
        check("R6 cleared 2", chg_data, 8'h0E);
    endtask

    task automatic t_upper_pins();
        set_pins(7'h7E);
        tick_once(); tick_once();
        check("R2 upper ignored", chg_data, 8'h0E);
        check("R1 upper readable", port_data, 8'hFE);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        set_pins(7'h7A);
        tick_once(); tick_once();
        check("R3 fall bit2", chg_data, 8'h4A);
        check("R10 mask zero", {7'd0, irq}, 8'h00);
        @(negedge clk) mask = 4'b0010;
        #1 check("R10 other mask", {7'd0, irq}, 8'h00);
        @(negedge clk) mask = 4'b0100;
        #1 check("R10 enabled", {7'd0, irq}, 8'h01);
        read_chg(v);
        check("R10 irq after read", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_read_collide();
        logic [7:0] v;
        set_pins(7'h7B);
        tick_once();
        @(negedge clk) begin tick = 1'b1; rd = 1'b1; end
        v = chg_data;
        @(negedge clk) begin tick = 1'b0; rd = 1'b0; end
        check("R7 read sees old", v, 8'h0A);
        check("R7 flag kept", chg_data, 8'h1B);
        read_chg(v);
        check("R7 later read", v, 8'h1B);
        check("R7 then clear", chg_data, 8'h0B);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_first_sample();
        t_glitch();
        t_rise_read();
        t_fall_sticky();
        t_upper_pins();
        t_irq();
        t_read_collide();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule